// File: doc/BRIEF.md
# Cycle-Counting PLL Lock Detector

This block decides whether a phase-locked loop is locked. It runs on the clock of the phase-frequency comparison, so one clock edge is one comparison cycle. On each cycle a front end (outside this block) reports two flags. The first says whether the reference and feedback edges arrived within the allowed error window. The second says whether the cycle showed a gross frequency error. The detector raises a registered lock status only after a long unbroken run of good comparisons. Once locked, it drops the status when bad cycles have built up an accumulated excess over good ones, or at once on a gross frequency error.

The two directions are deliberately asymmetric. With the default parameters, declaring lock needs 65535 consecutive good cycles. Losing lock takes from one cycle (gross error) up to 32768 cycles (a steady stream of bad comparisons). A restart input throws away all the evidence gathered so far and forces the status to unlocked. A sticky loss flag records any drop of lock and holds it until it is acknowledged. Both counter widths are parameters, so a system or a bench can use short thresholds.

Top module: `pll_lock_detect`

## Requirements
- R1: A cycle is bad when `in_window` is 0 or `gross_err` is 1; otherwise it is good. The run counter advances by one on every good cycle and returns to zero on every bad cycle.
- R2: From the unlocked state, `locked` goes to 1 on the clock edge on which the count of consecutive good cycles reaches 2^LOCK_W - 1. One bad cycle anywhere in the run means a further full run is needed.
- R3: While locked, an unlock accumulator is incremented on each bad cycle and decremented on each good cycle, with a floor of zero. `locked` goes to 0 on the edge on which the accumulator would reach 2^UNLK_W. With no good cycles in between, this happens on the 2^UNLK_W-th bad cycle.
- R4: A cycle with `gross_err` = 1 while locked makes `locked` 0 on that same clock edge, whatever the accumulator holds.
- R5: `restart` sampled high on an edge clears both counters and forces `locked` to 0 on that edge. It takes priority over lock, unlock and gross error, and it never sets `loss_of_lock`.
- R6: `loss_of_lock` is set on every edge on which lock is dropped by R3 or R4. It stays 1 until an edge samples `sticky_clr` high with no simultaneous drop. A drop on the same edge as `sticky_clr` leaves the flag at 1.
- R7: While `rst_n` is low, `locked` and `loss_of_lock` are 0 and both counters are zero.
- R8: Good cycles seen while unlocked leave the unlock accumulator at zero. Every new lock therefore starts with an empty accumulator, and a run of 2^UNLK_W bad cycles is needed to drop it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Comparison-rate clock, one edge per comparison cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_window | input | 1 | 1 when this cycle's edge error was inside the threshold |
| gross_err | input | 1 | 1 when this cycle showed a gross frequency error |
| restart | input | 1 | Discards all counts and forces the unlocked state |
| sticky_clr | input | 1 | Acknowledges and clears the sticky loss flag |
| locked | output | 1 | Registered lock status |
| loss_of_lock | output | 1 | Sticky flag, set whenever lock is dropped |

## Verification
The collisions that matter are restart arriving on the same edge as an unlock event, and the acknowledge of the sticky flag arriving on the same edge as a fresh drop of lock. The bench sets up each case directly. It relocks the loop, then applies `gross_err` together with `restart`, and expects `locked` at 0 with `loss_of_lock` still clear. It then applies `gross_err` together with `sticky_clr`, and expects the flag to stay set. Random stimulus with occasional restart and clear pulses produces further coincidences, and each cycle is compared against a cycle model in the bench.

// File: rtl/pld_pkg.sv
package pld_pkg;
  typedef struct packed {
    logic bad;
    logic gross;
    logic restart;
  } pfd_flags_t;
endpackage

// File: rtl/lock_run_ctr.sv
module lock_run_ctr
  import pld_pkg::*;
#(
  parameter int LOCK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pfd_flags_t        flags,
  output logic [LOCK_W-1:0] run_q,
  output logic              run_hit
);
  localparam logic [LOCK_W-1:0] RUN_MAX = {LOCK_W{1'b1}};
  localparam logic [LOCK_W-1:0] RUN_ONE = {{(LOCK_W-1){1'b0}}, 1'b1};

  logic [LOCK_W-1:0] run_nxt;
  logic              run_ce;

  always_comb begin
    if (flags.restart || flags.bad) begin
      run_nxt = '0;
    end else if (run_q == RUN_MAX) begin
      run_nxt = RUN_MAX;
    end else begin
      run_nxt = run_q + RUN_ONE;
    end
    run_ce  = (run_nxt != run_q);
    run_hit = (run_nxt == RUN_MAX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (run_ce) begin
      run_q <= run_nxt;
    end
  end

  // R1: any bad cycle empties the run counter
  a_r1_bad_clears : assert property (@(posedge clk) disable iff (!rst_n)
    flags.bad |=> (run_q == '0));

  // R1: a good cycle below the ceiling advances the count by exactly one
  a_r1_good_steps : assert property (@(posedge clk) disable iff (!rst_n)
    (!flags.bad && !flags.restart && run_q != RUN_MAX)
      |=> (run_q == $past(run_q) + RUN_ONE));
endmodule

// File: rtl/unlock_accum.sv
module unlock_accum
  import pld_pkg::*;
#(
  parameter int UNLK_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pfd_flags_t        flags,
  input  logic              locked_q,
  output logic [UNLK_W-1:0] acc_q,
  output logic              drop
);
  localparam logic [UNLK_W-1:0] ACC_TOP = {UNLK_W{1'b1}};
  localparam logic [UNLK_W-1:0] ACC_ONE = {{(UNLK_W-1){1'b0}}, 1'b1};

  logic [UNLK_W-1:0] acc_nxt;
  logic              acc_ce;

  always_comb begin
    drop = locked_q && !flags.restart &&
           (flags.gross || (flags.bad && acc_q == ACC_TOP));
    if (flags.restart || !locked_q || drop) begin
      acc_nxt = '0;
    end else if (flags.bad) begin
      acc_nxt = acc_q + ACC_ONE;
    end else if (acc_q != '0) begin
      acc_nxt = acc_q - ACC_ONE;
    end else begin
      acc_nxt = '0;
    end
    acc_ce = (acc_nxt != acc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_ce) begin
      acc_q <= acc_nxt;
    end
  end

  // R8: the accumulator stays empty whenever the status is unlocked
  a_r8_idle_when_unlocked : assert property (@(posedge clk) disable iff (!rst_n)
    !locked_q |-> (acc_q == '0));

  // R3: a good cycle while locked never raises the accumulator
  a_r3_good_decays : assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !flags.bad && !flags.restart && acc_q != '0)
      |=> (acc_q == $past(acc_q) - ACC_ONE));
endmodule

// File: rtl/pll_lock_detect.sv
module pll_lock_detect
  import pld_pkg::*;
#(
  parameter int LOCK_W = 16,
  parameter int UNLK_W = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_window,
  input  logic gross_err,
  input  logic restart,
  input  logic sticky_clr,
  output logic locked,
  output logic loss_of_lock
);
  localparam logic [LOCK_W-1:0] RUN_MAX = {LOCK_W{1'b1}};

  pfd_flags_t        flags;
  logic [LOCK_W-1:0] run_q;
  logic [UNLK_W-1:0] acc_q;
  logic              run_hit;
  logic              drop;
  logic              locked_q, locked_nxt;
  logic              loss_q, loss_nxt;

  always_comb begin
    flags.bad     = !in_window || gross_err;
    flags.gross   = gross_err;
    flags.restart = restart;
  end

  lock_run_ctr #(.LOCK_W(LOCK_W)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags   (flags),
    .run_q   (run_q),
    .run_hit (run_hit)
  );

  unlock_accum #(.UNLK_W(UNLK_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .flags    (flags),
    .locked_q (locked_q),
    .acc_q    (acc_q),
    .drop     (drop)
  );

  always_comb begin
    if (restart || drop) begin
      locked_nxt = 1'b0;
    end else if (!locked_q && run_hit) begin
      locked_nxt = 1'b1;
    end else begin
      locked_nxt = locked_q;
    end
    if (drop) begin
      loss_nxt = 1'b1;
    end else if (sticky_clr) begin
      loss_nxt = 1'b0;
    end else begin
      loss_nxt = loss_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
      loss_q   <= 1'b0;
    end else begin
      if (locked_nxt != locked_q) locked_q <= locked_nxt;
      if (loss_nxt != loss_q)     loss_q   <= loss_nxt;
    end
  end

  assign locked       = locked_q;
  assign loss_of_lock = loss_q;

  // R2: lock is only declared at the end of a full good run
  a_r2_rise_after_run : assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(locked_q) && locked_q) |-> (run_q == RUN_MAX));

  // R5: restart empties both counters and leaves the status unlocked
  a_r5_restart_clears : assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!locked_q && run_q == '0 && acc_q == '0));

  // R4: a gross error while locked drops lock and raises the sticky flag
  a_r4_gross_drops : assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && gross_err && !restart) |=> (!locked_q && loss_q));

  // R6: the sticky flag holds until acknowledged
  a_r6_sticky_holds : assert property (@(posedge clk) disable iff (!rst_n)
    (loss_q && !sticky_clr) |=> loss_q);

  // R7: outputs are quiet straight after reset release
  a_r7_reset_quiet : assert property (@(posedge clk)
    !rst_n |=> (!locked_q && !loss_q));
endmodule

// File: tb/pll_lock_detect_tb.sv
module pll_lock_detect_tb;
  localparam int LW = 4;
  localparam int UW = 3;
  localparam int LM = (1 << LW) - 1;
  localparam int UM = 1 << UW;

  logic clk = 1'b0;
  logic rst_n;
  logic in_window, gross_err, restart, sticky_clr;
  logic locked, loss_of_lock;

  int vectors = 0;
  int errors  = 0;
  int m_run, m_acc;
  bit m_lock, m_loss;
  string tag;

  always #2.5 clk = ~clk;

  pll_lock_detect #(.LOCK_W(LW), .UNLK_W(UW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_window(in_window), .gross_err(gross_err),
    .restart(restart), .sticky_clr(sticky_clr),
    .locked(locked), .loss_of_lock(loss_of_lock)
  );

  function automatic void model_step(bit iw, bit ge, bit rs, bit sc);
    bit bad, drop;
    int nrun;
    bad  = !iw || ge;
    drop = 1'b0;
    if (rs) begin
      m_run = 0; m_acc = 0; m_lock = 1'b0;
    end else begin
      drop = m_lock && (ge || (bad && m_acc + 1 == UM));
      nrun = bad ? 0 : ((m_run < LM) ? m_run + 1 : LM);
      if (drop) begin
        m_lock = 1'b0; m_acc = 0;
      end else if (m_lock) begin
        m_acc = bad ? m_acc + 1 : ((m_acc > 0) ? m_acc - 1 : 0);
      end else begin
        m_acc = 0;
        if (nrun == LM) m_lock = 1'b1;
      end
      m_run = nrun;
    end
    if (drop) m_loss = 1'b1;
    else if (sc) m_loss = 1'b0;
  endfunction

  task automatic check_outs();
    vectors++;
    if (locked !== m_lock || loss_of_lock !== m_loss) begin
      errors++;
      $display("FAIL %s: locked/loss actual %b%b expected %b%b at %0t",
               tag, locked, loss_of_lock, m_lock, m_loss, $time);
    end
  endtask

  task automatic cyc(bit iw, bit ge, bit rs, bit sc);
    in_window = iw; gross_err = ge; restart = rs; sticky_clr = sc;
    @(posedge clk);
    model_step(iw, ge, rs, sc);
    @(negedge clk);
    check_outs();
  endtask

  task automatic goods(int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic bads(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    rst_n = 1'b0; in_window = 1'b0; gross_err = 1'b0;
    restart = 1'b0; sticky_clr = 1'b0;
    m_run = 0; m_acc = 0; m_lock = 1'b0; m_loss = 1'b0;
    tag = "R7";
    repeat (3) @(negedge clk);
    check_outs();
    rst_n = 1'b1;
    cyc(1'b0, 1'b0, 1'b0, 1'b0);

    tag = "R1";                       // broken run must start over
    goods(10); bads(1); goods(LM - 1);
    tag = "R2";                       // completes the full run
    goods(1);

    tag = "R3";                       // accumulate with one decay step
    bads(UM - 1); goods(1); bads(1); bads(1);
    tag = "R6";                       // flag holds, then acknowledged
    goods(5); cyc(1'b1, 1'b0, 1'b0, 1'b1); goods(2);

    tag = "R8";                       // fresh lock needs a full bad run
    goods(LM); bads(UM - 1); bads(1);

    tag = "R4";
    goods(LM); bads(3); cyc(1'b1, 1'b1, 1'b0, 1'b0);
    tag = "R6";                       // drop and acknowledge together
    goods(LM); cyc(1'b1, 1'b1, 1'b0, 1'b1); goods(1);
    cyc(1'b1, 1'b0, 1'b0, 1'b1);

    tag = "R5";                       // restart against gross error
    goods(LM); cyc(1'b1, 1'b1, 1'b1, 1'b0);
    goods(10); cyc(1'b1, 1'b0, 1'b1, 1'b0); goods(LM - 1); goods(1);
    cyc(1'b1, 1'b0, 1'b1, 1'b0);

    tag = "R3";                       // mixed random traffic
    seed_v = $urandom(32'd20240611);
    for (int i = 0; i < 5000; i++) begin
      int unsigned r;
      r = $urandom % 1000;
      cyc((r % 100) >= 12, r < 4, r > 996, (r % 97) == 5);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule